// File: doc/BRIEF.md
# Paged Instruction Address Sequencer

This block holds the instruction address of a small 8-bit controller and computes the next one every cycle. The 14-bit address space is split into 16 pages of 1K words. The page number sits in the upper four bits. The 10-bit offset within the page sits in the lower ten. An 8-entry return stack saves the address that follows each call.

An external decoder drives one strobe per control-flow kind:

- sequential step
- jump
- call
- return
- accumulator move into the address
- accumulator add to the address
- table-lookup add

Each kind treats the upper bits differently. Jump, call, move and add take the page from four page-select bits supplied by a status register. Move and add also clear offset bits 9 and 8. The table-lookup add keeps every bit above the low byte untouched.

The return stack is circular. Once it is full, a further call overwrites the oldest saved address and raises a sticky overflow flag.

Top module: `paged_pc`

## Requirements
- R1: After reset the address output is 0, the return stack is empty and the overflow flag is 0.
- R2: A sequential step sets the address to the old address plus one, modulo 2^14, so 0x3FFF steps to 0x0000.
- R3: A jump sets address bits 13:10 to the page-select input and bits 9:0 to the 10-bit immediate.
- R4: A call loads the same target as a jump and pushes the old address plus one (modulo 2^14) onto the return stack.
- R5: A return loads the most recently pushed address and removes it from the stack, so nested calls unwind newest-first.
- R6: A move sets bits 13:10 to the page-select input, clears bits 9:8 and copies the 8-bit accumulator into bits 7:0.
- R7: An add sets bits 13:10 to the page-select input, clears bits 9:8 and sets bits 7:0 to the old bits 7:0 plus the accumulator, modulo 256.
- R8: A table-lookup add keeps bits 13:8 and sets bits 7:0 to the old bits 7:0 plus the accumulator, modulo 256. The page-select input has no effect.
- R9: With no strobe asserted the address holds its value.
- R10: When several strobes are asserted together, exactly one acts. The order of precedence is return, call, jump, move, add, table-lookup add, sequential step.
- R11: A ninth push without an intervening return overwrites the oldest entry and sets the overflow flag. The flag stays at 1 until reset. The following returns yield the latest eight pushed addresses, newest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| do_step | input | 1 | Sequential step strobe |
| do_jump | input | 1 | Jump strobe |
| do_call | input | 1 | Call strobe |
| do_ret | input | 1 | Return strobe (all return variants) |
| do_move | input | 1 | Accumulator move strobe |
| do_add | input | 1 | Accumulator add strobe |
| do_tbl | input | 1 | Table-lookup add strobe |
| imm | input | 10 | Immediate offset from the instruction |
| acc | input | 8 | Accumulator value |
| page_sel | input | 4 | Page-select bits from the status register |
| pc | output | 14 | Current instruction address |
| stk_ovf | output | 1 | Sticky return-stack overflow flag |

## Verification
Every strobe is sampled at a rising edge, and its effect on the address and on the overflow flag shows at that same edge. The result is therefore due one cycle after the stimulus is presented.

A return reads the stack entry written by an earlier call with no further delay. Its result is also due in that one cycle.

The driver presents each stimulus at a falling edge. It waits for the next rising edge and then queues the expected address and flag. The monitor compares at the following falling edge, a half cycle clear of any edge.

After reset is removed, the address is checked only once the two-stage internal release has completed.

// File: rtl/pgpc_pkg.sv
package pgpc_pkg;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_STEP,
    OP_JUMP,
    OP_CALL,
    OP_RET,
    OP_MOVE,
    OP_ADD,
    OP_TBL
  } pc_op_e;

  // Precedence: return, call, jump, move, add, table add, step.
  function automatic pc_op_e pick_op(input logic ret, input logic call,
                                     input logic jump, input logic move,
                                     input logic add, input logic tbl,
                                     input logic step);
    pc_op_e op;
    if (ret)       op = OP_RET;
    else if (call) op = OP_CALL;
    else if (jump) op = OP_JUMP;
    else if (move) op = OP_MOVE;
    else if (add)  op = OP_ADD;
    else if (tbl)  op = OP_TBL;
    else if (step) op = OP_STEP;
    else           op = OP_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/pgpc_stk.sv
module pgpc_stk #(
  parameter int DEPTH = 8,
  parameter int DW    = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] top,
  output logic          ovf
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DW-1:0]    slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_idx;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;

  // One register per entry, each with its own write enable.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wr_ptr_q == PTR_W'(g))) begin
        slot[g] <= din;
      end
    end
  end

  always_comb begin
    rd_idx = (wr_ptr_q == '0) ? LAST : wr_ptr_q - PTR_W'(1);
  end

  assign top = slot[rd_idx];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    ovf_d    = ovf_q;
    if (push) begin
      wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + PTR_W'(1);
      if (cnt_q == FULL) ovf_d = 1'b1;
      else               cnt_d = cnt_q + CNT_W'(1);
    end else if (pop) begin
      wr_ptr_d = rd_idx;
      if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else if (push || pop) begin
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
      ovf_q    <= ovf_d;
    end
  end

  assign ovf = ovf_q;

endmodule

// File: rtl/pgpc_nxt.sv
module pgpc_nxt
  import pgpc_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFS_W  = 10,
  parameter int ACC_W  = 8
) (
  input  pc_op_e                    op,
  input  logic [PAGE_W+OFS_W-1:0]   pc,
  input  logic [OFS_W-1:0]          imm,
  input  logic [ACC_W-1:0]          acc,
  input  logic [PAGE_W-1:0]         page,
  input  logic [PAGE_W+OFS_W-1:0]   top,
  output logic [PAGE_W+OFS_W-1:0]   nxt,
  output logic                      load,
  output logic                      push,
  output logic                      pop
);

  localparam int PC_W  = PAGE_W + OFS_W;
  localparam int MID_W = OFS_W - ACC_W;

  logic [PC_W-1:0]  pc_inc;
  logic [ACC_W-1:0] low_sum;

  assign pc_inc  = pc + PC_W'(1);
  assign low_sum = pc[ACC_W-1:0] + acc;

  always_comb begin
    nxt  = pc;
    push = 1'b0;
    pop  = 1'b0;
    unique case (op)
      OP_STEP: nxt = pc_inc;
      OP_JUMP: nxt = {page, imm};
      OP_CALL: begin
        nxt  = {page, imm};
        push = 1'b1;
      end
      OP_RET: begin
        nxt = top;
        pop = 1'b1;
      end
      OP_MOVE: nxt = {page, {MID_W{1'b0}}, acc};
      OP_ADD:  nxt = {page, {MID_W{1'b0}}, low_sum};
      OP_TBL:  nxt = {pc[PC_W-1:ACC_W], low_sum};
      default: nxt = pc;
    endcase
  end

  assign load = (op != OP_HOLD);

endmodule

// File: rtl/paged_pc.sv
module paged_pc
  import pgpc_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFS_W  = 10,
  parameter int ACC_W  = 8,
  parameter int DEPTH  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     do_step,
  input  logic                     do_jump,
  input  logic                     do_call,
  input  logic                     do_ret,
  input  logic                     do_move,
  input  logic                     do_add,
  input  logic                     do_tbl,
  input  logic [OFS_W-1:0]         imm,
  input  logic [ACC_W-1:0]         acc,
  input  logic [PAGE_W-1:0]        page_sel,
  output logic [PAGE_W+OFS_W-1:0]  pc,
  output logic                     stk_ovf
);

  localparam int PC_W = PAGE_W + OFS_W;

  logic            rst_s1, rst_q;
  pc_op_e          op;
  logic [PC_W-1:0] pc_q, pc_d, top, ret_addr;
  logic            load, push, pop;

  // Asynchronous assertion, release after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  assign op       = pick_op(do_ret, do_call, do_jump, do_move, do_add, do_tbl, do_step);
  assign ret_addr = pc_q + PC_W'(1);

  pgpc_nxt #(
    .PAGE_W (PAGE_W),
    .OFS_W  (OFS_W),
    .ACC_W  (ACC_W)
  ) u_nxt (
    .op   (op),
    .pc   (pc_q),
    .imm  (imm),
    .acc  (acc),
    .page (page_sel),
    .top  (top),
    .nxt  (pc_d),
    .load (load),
    .push (push),
    .pop  (pop)
  );

  pgpc_stk #(
    .DEPTH (DEPTH),
    .DW    (PC_W)
  ) u_stk (
    .clk   (clk),
    .rst_n (rst_q),
    .push  (push),
    .pop   (pop),
    .din   (ret_addr),
    .top   (top),
    .ovf   (stk_ovf)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pc_q <= '0;
    end else if (load) begin
      pc_q <= pc_d;
    end
  end

  assign pc = pc_q;

endmodule

// File: rtl/pgpc_chk.sv
module pgpc_chk #(
  parameter int PAGE_W = 4,
  parameter int OFS_W  = 10,
  parameter int ACC_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    do_step,
  input logic                    do_jump,
  input logic                    do_call,
  input logic                    do_ret,
  input logic                    do_move,
  input logic                    do_add,
  input logic                    do_tbl,
  input logic [OFS_W-1:0]        imm,
  input logic [ACC_W-1:0]        acc,
  input logic [PAGE_W-1:0]       page_sel,
  input logic [PAGE_W+OFS_W-1:0] pc,
  input logic                    stk_ovf
);

  localparam int PC_W = PAGE_W + OFS_W;

  logic above_jump, above_move, above_tbl, above_step, none;

  assign above_jump = do_ret | do_call;
  assign above_move = above_jump | do_jump;
  assign above_tbl  = above_move | do_move | do_add;
  assign above_step = above_tbl | do_tbl;
  assign none       = ~(above_step | do_step);

  // R2
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && !above_step) |=> pc == PC_W'($past(pc) + PC_W'(1)));

  // R3
  assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_jump && !above_jump) |=> pc == {$past(page_sel), $past(imm)});

  // R4
  assert_call_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_call && !do_ret) |=> pc == {$past(page_sel), $past(imm)});

  // R6
  assert_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_move && !above_move) |=>
      (pc[OFS_W-1:ACC_W] == '0) && (pc[ACC_W-1:0] == $past(acc)));

  // R8
  assert_tbl_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (do_tbl && !above_tbl) |=> pc[PC_W-1:ACC_W] == $past(pc[PC_W-1:ACC_W]));

  // R9
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    none |=> $stable(pc));

  // R11
  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |=> stk_ovf);

endmodule

bind paged_pc pgpc_chk #(
  .PAGE_W (PAGE_W),
  .OFS_W  (OFS_W),
  .ACC_W  (ACC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .do_step  (do_step),
  .do_jump  (do_jump),
  .do_call  (do_call),
  .do_ret   (do_ret),
  .do_move  (do_move),
  .do_add   (do_add),
  .do_tbl   (do_tbl),
  .imm      (imm),
  .acc      (acc),
  .page_sel (page_sel),
  .pc       (pc),
  .stk_ovf  (stk_ovf)
);

// File: tb/sim_paged_pc.sv
module sim_paged_pc;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       do_step = 0, do_jump = 0, do_call = 0, do_ret = 0;
  logic       do_move = 0, do_add = 0, do_tbl = 0;
  logic [9:0] imm = '0;
  logic [7:0] acc = '0;
  logic [3:0] page_sel = '0;
  logic [13:0] pc;
  logic        stk_ovf;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [13:0] pc;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  // independent model state
  logic [13:0] mpc;
  logic [13:0] mstk [8];
  int          mptr, mdepth;
  logic        movf;

  localparam logic [6:0] S_RET = 7'b1000000, S_CALL = 7'b0100000,
                         S_JMP = 7'b0010000, S_MOV  = 7'b0001000,
                         S_ADD = 7'b0000100, S_TBL  = 7'b0000010,
                         S_STP = 7'b0000001, S_NONE = 7'b0000000;

  always #10 clk = ~clk;

  paged_pc u0 (
    .clk (clk), .rst_n (rst_n),
    .do_step (do_step), .do_jump (do_jump), .do_call (do_call),
    .do_ret (do_ret), .do_move (do_move), .do_add (do_add), .do_tbl (do_tbl),
    .imm (imm), .acc (acc), .page_sel (page_sel),
    .pc (pc), .stk_ovf (stk_ovf)
  );

  task automatic model(input logic [6:0] s);
    logic [7:0] sum;
    sum = mpc[7:0] + acc;
    if (s[6]) begin
      mptr = (mptr + 7) % 8;
      mpc  = mstk[mptr];
      if (mdepth > 0) mdepth--;
    end else if (s[5]) begin
      mstk[mptr] = mpc + 14'd1;
      mptr = (mptr + 1) % 8;
      if (mdepth == 8) movf = 1'b1; else mdepth++;
      mpc = {page_sel, imm};
    end else if (s[4]) mpc = {page_sel, imm};
    else if (s[3])     mpc = {page_sel, 2'b00, acc};
    else if (s[2])     mpc = {page_sel, 2'b00, sum};
    else if (s[1])     mpc = {mpc[13:8], sum};
    else if (s[0])     mpc = mpc + 14'd1;
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic step(input logic [6:0] s, input logic [3:0] pg,
                      input logic [9:0] im, input logic [7:0] ac,
                      input string tag);
    exp_t e;
    {do_ret, do_call, do_jump, do_move, do_add, do_tbl, do_step} = s;
    page_sel = pg; imm = im; acc = ac;
    @(posedge clk);
    #1;
    model(s);
    e.pc = mpc; e.ovf = movf; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    {do_ret, do_call, do_jump, do_move, do_add, do_tbl, do_step} = S_NONE;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (pc !== e.pc || stk_ovf !== e.ovf) begin
          errors++;
          $display("FAIL %s: pc=%h ovf=%b expected pc=%h ovf=%b",
                   e.tag, pc, stk_ovf, e.pc, e.ovf);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mpc = '0; mptr = 0; mdepth = 0; movf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (pc !== 14'h0 || stk_ovf !== 1'b0) begin
      errors++;
      $display("FAIL R1: pc=%h ovf=%b expected pc=0000 ovf=0", pc, stk_ovf);
    end

    step(S_STP, 4'h0, 10'h0, 8'h0, "R2 step");
    step(S_STP, 4'h0, 10'h0, 8'h0, "R2 step");
    step(S_STP, 4'h0, 10'h0, 8'h0, "R2 step");
    step(S_JMP, 4'h5, 10'h123, 8'h0, "R3 jump");
    step(S_CALL, 4'h2, 10'h010, 8'h0, "R4 call");
    step(S_CALL, 4'h3, 10'h020, 8'h0, "R4 nested call");
    step(S_RET, 4'h0, 10'h0, 8'h0, "R5 return inner");
    step(S_RET, 4'h0, 10'h0, 8'h0, "R5 return outer");
    step(S_MOV, 4'h7, 10'h3FF, 8'h5A, "R6 move");
    step(S_JMP, 4'h1, 10'h3F0, 8'h0, "R3 jump");
    step(S_ADD, 4'h9, 10'h0, 8'h20, "R7 add wraps low byte");
    step(S_JMP, 4'h4, 10'h2F8, 8'h0, "R3 jump");
    step(S_TBL, 4'hC, 10'h0, 8'h10, "R8 table add keeps high bits");
    step(S_NONE, 4'hF, 10'h3FF, 8'hFF, "R9 hold");
    step(S_NONE, 4'h1, 10'h001, 8'h01, "R9 hold");
    step(S_CALL | S_JMP | S_STP, 4'h6, 10'h044, 8'h0, "R10 call over jump");
    step(S_JMP | S_MOV | S_STP, 4'h8, 10'h155, 8'h33, "R10 jump over move");
    step(S_MOV | S_ADD, 4'hA, 10'h0, 8'h77, "R10 move over add");
    step(S_ADD | S_TBL, 4'hB, 10'h0, 8'h11, "R10 add over table");
    step(S_TBL | S_STP, 4'h2, 10'h0, 8'h05, "R10 table over step");
    step(S_RET | S_CALL | S_STP, 4'h3, 10'h0, 8'h0, "R10 return first");
    step(S_JMP, 4'hF, 10'h3FF, 8'h0, "R3 jump to top");
    step(S_STP, 4'h0, 10'h0, 8'h0, "R2 wrap to zero");
    for (int i = 0; i < 9; i++) begin
      step(S_CALL, 4'(i), 10'(i * 37 + 5), 8'h0, "R11 push");
    end
    for (int i = 0; i < 8; i++) begin
      step(S_RET, 4'h0, 10'h0, 8'h0, "R11 pop after overflow");
    end
    step(S_STP, 4'h0, 10'h0, 8'h0, "R11 flag stays set");
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule